// File: doc/BRIEF.md
# Watch-High Register Bank

This block holds eight 64-bit watchpoint-high control registers for a system-control coprocessor. Software picks one register with a 3-bit select index. It reaches that register through one of three access types: a 32-bit low-word access, a high-word access used by 32-bit cores, and a full 64-bit access used by 64-bit cores. Writes pass through a field mask, so only the defined fields can change. The mask keeps the global bit, the address-mask field and an address-space-identifier field whose width is a parameter. A configuration input enables a 32-bit memory-map identifier in the upper half of each register. When that input is low, the upper half cannot be written, and a high-word access is reported as unimplemented.

The three lowest bits of each register are match-status flags. A watch comparator outside this block sets them through a per-register hit port. Software clears a flag by writing 1 to it. Reads are combinational from the selected register. Writes take effect on the rising clock edge.

Top module: `watchhi_bank`

## Requirements
- R1: A synchronous active-high `rst` clears all registers to zero on the next rising edge.
- R2: A low-word write (`acc_type` 2'b00) or a full write (`acc_type` 2'b10) stores only these bits of `wdata[31:3]`: bit 30, bits 11:3, and bits 16 to 16+ASID_W-1. All other bits of 31:3 become zero. A low-word write leaves bits 63:32 unchanged.
- R3: On a full write, bits 63:32 take `wdata[63:32]` when `mi_en` is 1, and become zero when `mi_en` is 0.
- R4: A high-word write (`acc_type` 2'b01) with `mi_en` at 1 replaces bits 63:32 with `wdata[31:0]` and leaves bits 31:0 unchanged, including the status flags.
- R5: A low-word read (`acc_type` 2'b00) returns bits 31:0 of the selected register on `rdata[31:0]`. `rdata[63:32]` carries copies of bit 31.
- R6: A high-word read (`acc_type` 2'b01) returns bits 63:32 of the selected register on `rdata[31:0]`, with `rdata[63:32]` at zero.
- R7: A full read (`acc_type` 2'b10) returns all 64 bits of the selected register unchanged. Access type 2'b11 reads as zero.
- R8: When `mi_en` is 0, a high-word access with `wr_en` or `rd_en` set raises `err` in the same cycle and changes no register. `err` is never raised while `mi_en` is 1.
- R9: Bits 2:0 of register i are status flags. Each flag is set by a 1 on `hit[3*i+2:3*i]`. A low-word or full write clears the flags whose `wdata[2:0]` bit is 1 and keeps the flags whose bit is 0.
- R10: If a hit and a clearing write reach the same flag in the same cycle, the flag ends up set.
- R11: A write changes only the selected register. A write with access type 2'b11 changes nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; only affects error reporting |
| acc_type | input | 2 | 00 low word, 01 high word, 10 full, 11 none |
| sel | input | 3 | Register select index |
| wdata | input | 64 | Write data; a high-word write uses bits 31:0 |
| mi_en | input | 1 | Memory-map identifier enable |
| hit | input | 24 | Per-register status set pulses, 3 per register |
| rdata | output | 64 | Combinational read data |
| err | output | 1 | Unimplemented high-word access |

## Verification
Read data and `err` are combinational, so each is due in the same cycle as the select and access type. The bench drives its inputs at the falling edge and compares them a moment later, before any rising edge. A write or a hit pulse is visible on a read from the cycle after the rising edge on which it was presented. The bench's register model therefore updates exactly at that edge, and every later read is compared against the updated model. A full read of every register at the end checks that no register was touched without cause.

// File: rtl/watchhi_pkg.sv
package watchhi_pkg;

  localparam int REG_W  = 64;
  localparam int HALF_W = 32;
  localparam int FLAG_W = 3;

  typedef enum logic [1:0] {
    ACC_LOW  = 2'b00,
    ACC_HIGH = 2'b01,
    ACC_FULL = 2'b10,
    ACC_NONE = 2'b11
  } acc_e;

  // Writable bits of the low word, flags excluded.
  function automatic logic [HALF_W-1:0] low_keep_mask(input int asid_w);
    logic [HALF_W-1:0] asid_ones;
    asid_ones = (32'd1 << asid_w) - 32'd1;
    return 32'h4000_0FF8 | (asid_ones << 16);
  endfunction

endpackage

// File: rtl/watchhi_wrdec.sv
module watchhi_wrdec
  import watchhi_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ASID_W   = 8,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic                 wr_en,
  input  logic                 rd_en,
  input  acc_e                 acc,
  input  logic [SEL_W-1:0]     sel,
  input  logic [REG_W-1:0]     wdata,
  input  logic                 mi_en,
  output logic [NUM_REGS-1:0]  wr_low_vec,
  output logic [NUM_REGS-1:0]  wr_high_vec,
  output logic [HALF_W-1:0]    low_val,
  output logic [HALF_W-1:0]    high_val,
  output logic [FLAG_W-1:0]    clr,
  output logic                 acc_err
);

  localparam logic [HALF_W-1:0] KEEP = low_keep_mask(ASID_W);
  localparam logic [NUM_REGS-1:0] ONE = {{(NUM_REGS-1){1'b0}}, 1'b1};

  logic low_go;
  logic high_go;

  always_comb begin
    low_go   = wr_en && (acc == ACC_LOW || acc == ACC_FULL);
    high_go  = wr_en && ((acc == ACC_HIGH && mi_en) || acc == ACC_FULL);
    low_val  = wdata[HALF_W-1:0] & KEEP;
    clr      = wdata[FLAG_W-1:0];
    if (acc == ACC_FULL)
      high_val = mi_en ? wdata[REG_W-1:HALF_W] : '0;
    else
      high_val = wdata[HALF_W-1:0];
    wr_low_vec  = low_go  ? (ONE << sel) : '0;
    wr_high_vec = high_go ? (ONE << sel) : '0;
    acc_err     = (wr_en || rd_en) && acc == ACC_HIGH && !mi_en;
  end

endmodule

// File: rtl/watchhi_entry.sv
module watchhi_entry
  import watchhi_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_low,
  input  logic              wr_high,
  input  logic [HALF_W-1:0] low_val,
  input  logic [HALF_W-1:0] high_val,
  input  logic [FLAG_W-1:0] clr,
  input  logic [FLAG_W-1:0] hit,
  output logic [REG_W-1:0]  q
);

  logic [FLAG_W-1:0] flag_nxt;

  // A hit outranks a clear aimed at the same flag.
  always_comb
    flag_nxt = (q[FLAG_W-1:0] & ~(wr_low ? clr : '0)) | hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else begin
      if (wr_low)
        q[HALF_W-1:FLAG_W] <= low_val[HALF_W-1:FLAG_W];
      if (wr_high)
        q[REG_W-1:HALF_W] <= high_val;
      q[FLAG_W-1:0] <= flag_nxt;
    end
  end

endmodule

// File: rtl/watchhi_rdmux.sv
module watchhi_rdmux
  import watchhi_pkg::*;
#(
  parameter int NUM_REGS = 8,
  localparam int SEL_W   = $clog2(NUM_REGS)
) (
  input  logic [NUM_REGS-1:0][REG_W-1:0] regs,
  input  logic [SEL_W-1:0]               sel,
  input  acc_e                           acc,
  output logic [REG_W-1:0]               rdata
);

  logic [REG_W-1:0] cur;

  always_comb begin
    cur = regs[sel];
    case (acc)
      ACC_LOW:  rdata = {{HALF_W{cur[HALF_W-1]}}, cur[HALF_W-1:0]};
      ACC_HIGH: rdata = {{HALF_W{1'b0}}, cur[REG_W-1:HALF_W]};
      ACC_FULL: rdata = cur;
      default:  rdata = '0;
    endcase
  end

endmodule

// File: rtl/watchhi_bank.sv
module watchhi_bank
  import watchhi_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ASID_W   = 8,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int HIT_W   = NUM_REGS * FLAG_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             rd_en,
  input  logic [1:0]       acc_type,
  input  logic [SEL_W-1:0] sel,
  input  logic [REG_W-1:0] wdata,
  input  logic             mi_en,
  input  logic [HIT_W-1:0] hit,
  output logic [REG_W-1:0] rdata,
  output logic             err
);

  acc_e                           acc;
  logic [NUM_REGS-1:0]            wr_low_vec;
  logic [NUM_REGS-1:0]            wr_high_vec;
  logic [HALF_W-1:0]              low_val;
  logic [HALF_W-1:0]              high_val;
  logic [FLAG_W-1:0]              clr;
  logic [NUM_REGS-1:0][REG_W-1:0] regs_q;

  assign acc = acc_e'(acc_type);

  watchhi_wrdec #(.NUM_REGS(NUM_REGS), .ASID_W(ASID_W)) u_dec (
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .acc        (acc),
    .sel        (sel),
    .wdata      (wdata),
    .mi_en      (mi_en),
    .wr_low_vec (wr_low_vec),
    .wr_high_vec(wr_high_vec),
    .low_val    (low_val),
    .high_val   (high_val),
    .clr        (clr),
    .acc_err    (err)
  );

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    watchhi_entry u_ent (
      .clk     (clk),
      .rst     (rst),
      .wr_low  (wr_low_vec[g]),
      .wr_high (wr_high_vec[g]),
      .low_val (low_val),
      .high_val(high_val),
      .clr     (clr),
      .hit     (hit[g*FLAG_W +: FLAG_W]),
      .q       (regs_q[g])
    );
  end

  watchhi_rdmux #(.NUM_REGS(NUM_REGS)) u_rd (
    .regs (regs_q),
    .sel  (sel),
    .acc  (acc),
    .rdata(rdata)
  );

endmodule

// File: rtl/watchhi_bank_chk.sv
module watchhi_bank_chk
  import watchhi_pkg::*;
#(
  parameter int NUM_REGS = 8,
  parameter int ASID_W   = 8,
  localparam int SEL_W   = $clog2(NUM_REGS),
  localparam int HIT_W   = NUM_REGS * FLAG_W
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           wr_en,
  input logic                           rd_en,
  input logic [1:0]                     acc_type,
  input logic [SEL_W-1:0]               sel,
  input logic                           mi_en,
  input logic [HIT_W-1:0]               hit,
  input logic [REG_W-1:0]               rdata,
  input logic                           err,
  input logic [NUM_REGS-1:0][REG_W-1:0] regs_q
);

  localparam logic [HALF_W-1:0] KEEP_ALL = low_keep_mask(ASID_W) | 32'h7;

  logic [HIT_W-1:0] flags;
  always_comb
    for (int i = 0; i < NUM_REGS; i++)
      flags[i*FLAG_W +: FLAG_W] = regs_q[i][FLAG_W-1:0];

  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (regs_q == '0)); // R1

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_mask
    AST_LOW_MASK: assert property (@(posedge clk) disable iff (rst)
      (regs_q[g][HALF_W-1:0] & ~KEEP_ALL) == '0); // R2
  end

  AST_FULL_NO_MMID: assert property (@(posedge clk) disable iff (rst)
    (wr_en && acc_type == 2'b10 && !mi_en) |=> (regs_q[$past(sel)][REG_W-1:HALF_W] == '0)); // R3

  AST_HIGH_READ_ZERO_TOP: assert property (@(posedge clk) disable iff (rst)
    (acc_type == 2'b01) |-> (rdata[REG_W-1:HALF_W] == '0)); // R6

  AST_ERR_RAISED: assert property (@(posedge clk) disable iff (rst)
    (acc_type == 2'b01 && !mi_en && (wr_en || rd_en)) |-> err); // R8

  AST_ERR_QUIET: assert property (@(posedge clk) disable iff (rst)
    mi_en |-> !err); // R8

  AST_ERR_NO_CHANGE: assert property (@(posedge clk) disable iff (rst)
    (err && hit == '0) |=> $stable(regs_q)); // R8

  AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
    (hit != '0) |=> ((flags & $past(hit)) == $past(hit))); // R10

endmodule

bind watchhi_bank watchhi_bank_chk #(.NUM_REGS(NUM_REGS), .ASID_W(ASID_W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .acc_type(acc_type),
  .sel     (sel),
  .mi_en   (mi_en),
  .hit     (hit),
  .rdata   (rdata),
  .err     (err),
  .regs_q  (regs_q)
);

// File: tb/tb_watchhi_bank.sv
module tb_watchhi_bank;

  localparam int N     = 8;
  localparam int ASIDW = 8;
  localparam logic [31:0] KEEP = 32'h4000_0FF8 | (((32'd1 << ASIDW) - 32'd1) << 16);

  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic        rd_en;
  logic [1:0]  acc_type;
  logic [2:0]  sel;
  logic [63:0] wdata;
  logic        mi_en;
  logic [23:0] hit;
  logic [63:0] rdata;
  logic        err;

  logic [63:0] model [N];
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  watchhi_bank #(.NUM_REGS(N), .ASID_W(ASIDW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .acc_type(acc_type),
    .sel(sel), .wdata(wdata), .mi_en(mi_en), .hit(hit), .rdata(rdata), .err(err)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] exp_read(input logic [2:0] s, input logic [1:0] a);
    logic [63:0] r;
    r = model[s];
    case (a)
      2'b00:   return {{32{r[31]}}, r[31:0]};
      2'b01:   return {32'h0, r[63:32]};
      2'b10:   return r;
      default: return 64'h0;
    endcase
  endfunction

  function automatic logic exp_err();
    return (wr_en || rd_en) && acc_type == 2'b01 && !mi_en;
  endfunction

  // One clock: the model advances on the rising edge, inputs come back idle.
  task automatic tick();
    logic [63:0] nxt [N];
    for (int i = 0; i < N; i++) begin
      nxt[i] = model[i];
      if (rst) begin
        nxt[i] = 64'h0;
      end else begin
        if (wr_en && sel == 3'(i)) begin
          if (acc_type == 2'b00 || acc_type == 2'b10) begin
            nxt[i][31:3] = wdata[31:3] & KEEP[31:3];
            nxt[i][2:0]  = model[i][2:0] & ~wdata[2:0];
          end
          if (acc_type == 2'b10)
            nxt[i][63:32] = mi_en ? wdata[63:32] : 32'h0;
          if (acc_type == 2'b01 && mi_en)
            nxt[i][63:32] = wdata[31:0];
        end
        nxt[i][2:0] = nxt[i][2:0] | hit[i*3 +: 3];
      end
    end
    @(posedge clk);
    for (int i = 0; i < N; i++) model[i] = nxt[i];
    @(negedge clk);
    rst = 1'b0; wr_en = 1'b0; rd_en = 1'b0; hit = '0; acc_type = 2'b11;
  endtask

  task automatic wr(input logic [2:0] s, input logic [1:0] a, input logic [63:0] d, input logic mi);
    sel = s; acc_type = a; wdata = d; mi_en = mi; wr_en = 1'b1;
    tick();
  endtask

  task automatic rd(input string tag, input logic [2:0] s, input logic [1:0] a, input logic [63:0] exp);
    sel = s; acc_type = a; rd_en = 1'b1; wr_en = 1'b0;
    #1;
    chk(tag, rdata, exp);
    rd_en = 1'b0;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; wr_en = 0; rd_en = 0; acc_type = 2'b11; sel = 0; wdata = '0; mi_en = 0; hit = '0;
    for (int i = 0; i < N; i++) model[i] = 64'hX;
    @(negedge clk);
    rst = 1'b1;
    tick();
    for (int i = 0; i < N; i++) rd("R1 reset", 3'(i), 2'b10, 64'h0);

    // R2: mask on a low-word write of all ones
    wr(3'd2, 2'b00, 64'hFFFF_FFFF_FFFF_FFF8, 1'b1);
    rd("R2 low mask", 3'd2, 2'b10, {32'h0, KEEP});

    // R3: full writes with and without the identifier field
    wr(3'd3, 2'b10, 64'hDEAD_BEEF_FFFF_FFF8, 1'b1);
    rd("R3 full mi=1", 3'd3, 2'b10, {32'hDEAD_BEEF, KEEP});
    wr(3'd4, 2'b10, 64'hDEAD_BEEF_FFFF_FFF8, 1'b0);
    rd("R3 full mi=0", 3'd4, 2'b10, {32'h0, KEEP});

    // R4 / R6: high-word write then high read
    wr(3'd3, 2'b01, 64'h0000_0000_1234_5678, 1'b1);
    rd("R4 high write", 3'd3, 2'b10, {32'h1234_5678, KEEP});
    rd("R6 high read", 3'd3, 2'b01, 64'h0000_0000_1234_5678);
    rd("R5 low read", 3'd3, 2'b00, {32'h0, KEEP});
    rd("R7 none read", 3'd3, 2'b11, 64'h0);

    // R8: high access with identifier disabled
    sel = 3'd3; acc_type = 2'b01; wdata = 64'hFFFF_FFFF; mi_en = 1'b0; wr_en = 1'b1;
    #1; chk("R8 err on write", {63'h0, err}, 64'h1);
    tick();
    rd("R8 no change", 3'd3, 2'b10, {32'h1234_5678, KEEP});
    mi_en = 1'b0;
    sel = 3'd3; acc_type = 2'b01; rd_en = 1'b1;
    #1; chk("R8 err on read", {63'h0, err}, 64'h1);
    rd_en = 1'b0;
    mi_en = 1'b1;
    sel = 3'd3; acc_type = 2'b01; rd_en = 1'b1;
    #1; chk("R8 quiet", {63'h0, err}, 64'h0);
    rd_en = 1'b0;

    // R9: set, partial clear, high write leaves flags
    hit[5*3 +: 3] = 3'b101;
    tick();
    rd("R9 hit set", 3'd5, 2'b10, 64'h5);
    wr(3'd5, 2'b00, 64'h1, 1'b1);
    rd("R9 w1 clear", 3'd5, 2'b10, 64'h4);
    wr(3'd5, 2'b01, 64'hFFFF_FFFF, 1'b1);
    rd("R9 high keeps flags", 3'd5, 2'b10, 64'hFFFF_FFFF_0000_0004);

    // R10: hit beats clear
    hit[5*3 +: 3] = 3'b100;
    wr(3'd5, 2'b00, 64'h4, 1'b1);
    rd("R10 hit wins", 3'd5, 2'b10, 64'hFFFF_FFFF_0000_0004);

    // R11: reserved access type writes nothing
    wr(3'd6, 2'b11, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    rd("R11 none write", 3'd6, 2'b10, 64'h0);

    // Random traffic
    for (int n = 0; n < 3000; n++) begin
      sel      = 3'($urandom_range(0, 7));
      acc_type = 2'($urandom_range(0, 3));
      mi_en    = 1'($urandom_range(0, 1));
      wdata    = {$urandom, $urandom};
      rd_en    = 1'($urandom_range(0, 1));
      wr_en    = ($urandom_range(0, 2) == 0);
      hit      = ($urandom_range(0, 5) == 0) ? 24'($urandom) : 24'h0;
      #1;
      case (acc_type)
        2'b00:   chk("R5 rand low read", rdata, exp_read(sel, acc_type));
        2'b01:   chk("R6 rand high read", rdata, exp_read(sel, acc_type));
        default: chk("R7 rand full read", rdata, exp_read(sel, acc_type));
      endcase
      chk("R8 rand err", {63'h0, err}, {63'h0, exp_err()});
      tick();
    end

    for (int i = 0; i < N; i++) rd("R11 final sweep", 3'(i), 2'b10, model[i]);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule